// File: doc/BRIEF.md
# Prioritized DMA Memory Bus Arbiter

This block shares one single-port on-chip data RAM between a CPU port and twelve DMA requesters. The requesters are an SPI engine, receive and transmit paths for four UARTs, an LCD-module interface, a memory-to-memory mover and an ADC scanner. The CPU always owns the RAM port in any cycle in which it asks for it. The DMA requesters compete for the remaining cycles. Each channel has a 2-bit programmable priority. When several channels share the highest pending priority, a fixed positional order picks the winner.

Software programs each channel with a priority, a start address and a length code, then pulses the channel's start bit. From then on, every granted request moves exactly one byte. Each grant advances the channel's address and decrements its remaining count. After the final byte, the channel raises a one-cycle done pulse and drops out of arbitration. The memory-to-memory channel reads a byte from its source address and writes it to a separate destination address, so it needs two grants for each byte. A requester that is not granted simply keeps its request high, and its pending work is held.

Grants and the RAM port controls are combinational in the request cycle, and the RAM read data is expected in that same cycle. Counters, addresses, active flags and done pulses are registered.

Top module: `dma_ram_arbiter`

## Requirements
- R1: Channel indices are fixed as follows: 0 SPI, 1 UART1 RX, 2 UART1 TX, 3 UART2 RX, 4 UART2 TX, 5 UART3 RX, 6 UART3 TX, 7 UART4 RX, 8 UART4 TX, 9 LCD, 10 memory-to-memory, 11 ADC. Among eligible requesters of equal priority, the lowest index is granted.
- R2: The priority of channel i is `chPrio[2i+1:2i]`. Value 3 is the highest and 0 the lowest. An eligible requester of higher priority always wins over one of lower priority.
- R3: While `cpuReq` is high, the RAM port carries the CPU address, write data and write enable, `ramEn` is high, and no DMA grant is issued in that cycle.
- R4: At most one bit of `dmaGnt` is high in any cycle. A grant is given only to a channel that is requesting, enabled and active.
- R5: A start pulse on an enabled channel loads the length code L from `chLen[8i+7:8i]`, and the transfer moves L+1 bytes (so 1 to 256 bytes). The done bit rises in the cycle after the final byte's grant, for one cycle. After that, the channel is not granted again until it is restarted.
- R6: The k-th byte grant of a channel (counting from 0) drives `ramAddr` = base + k. `ramWe` follows `dmaWr[i]`, and `ramWdata` is taken from `dmaWdata[8i+7:8i]`.
- R7: Channel 10 alternates two grants for each byte. The first grant is a read at source base + k. The second grant is a write, at `m2mDst` + k, of the byte just read. The done pulse follows the final write.
- R8: A channel whose `chEnable` bit is low is never granted, even while it is requesting. Raising the enable bit again resumes its pending transfer.
- R9: While `rstN` is low at a clock edge, all active flags, counters and done bits are cleared. After reset, no grant is issued until a channel is started.
- R10: A requester that loses arbitration and holds its request is granted in a later cycle, once no higher-ranked eligible requester remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| chEnable | input | 12 | Per-channel enable |
| chStart | input | 12 | Per-channel start pulse; loads the length and base |
| chPrio | input | 24 | Per-channel 2-bit priority |
| chLen | input | 96 | Per-channel length code (bytes minus one) |
| chBase | input | 192 | Per-channel start address (source address for channel 10) |
| m2mDst | input | 16 | Destination start address for the memory-to-memory channel |
| dmaReq | input | 12 | Per-channel access request |
| dmaWr | input | 12 | Per-channel direction: 1 writes RAM, 0 reads it |
| dmaWdata | input | 96 | Per-channel write byte |
| dmaGnt | output | 12 | Per-channel grant, one byte access |
| dmaDone | output | 12 | One-cycle pulse after the final byte |
| dmaRdata | output | 8 | Read byte for the granted channel |
| cpuReq | input | 1 | CPU access request, always served |
| cpuWe | input | 1 | CPU write enable |
| cpuAddr | input | 16 | CPU address |
| cpuWdata | input | 8 | CPU write byte |
| cpuRdata | output | 8 | CPU read byte |
| ramAddr | output | 16 | RAM address |
| ramWdata | output | 8 | RAM write byte |
| ramWe | output | 1 | RAM write enable |
| ramEn | output | 1 | RAM access enable |
| ramRdata | input | 8 | RAM read byte, valid in the same cycle |

## Verification
The assertions check, on every cycle, the following: that grants are one-hot or empty, that each grant goes to a requesting, enabled and active channel, that the grant respects priority and then index, that a CPU request takes the port and blocks every DMA grant, that done pulses only follow a grant, and that the block is quiet after reset. Some behaviour appears only across a whole sequence, so only the directed scenarios can show it: the exact byte count for a given length code, the address walk, the read-then-write interleave of the memory mover with its copied data, a masked channel resuming once re-enabled, and deferred requesters being served in order.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int NUM_CH  = 12;
  localparam int PRIO_W  = 2;
  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int IDX_W   = $clog2(NUM_CH);
  localparam int M2M_CH  = 10;

  // Channel positions; the index is also the tie-break rank (lower wins).
  typedef enum logic [IDX_W-1:0] {
    CH_SPI   = 4'd0,
    CH_U1RX  = 4'd1,
    CH_U1TX  = 4'd2,
    CH_U2RX  = 4'd3,
    CH_U2TX  = 4'd4,
    CH_U3RX  = 4'd5,
    CH_U3TX  = 4'd6,
    CH_U4RX  = 4'd7,
    CH_U4TX  = 4'd8,
    CH_LCD   = 4'd9,
    CH_M2M   = 4'd10,
    CH_ADC   = 4'd11
  } chIdx_e;

  // Strobes from arbitration control to the datapath.
  typedef struct packed {
    logic [NUM_CH-1:0] gnt;
    logic              cpuTake;
    logic              anyGnt;
  } strobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic [NUM_CH-1:0]        eligible,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  logic                     cpuReq,
  output strobe_t                  strobe
);
  logic [NUM_CH-1:0] levelMask [NUM_LVL];
  logic [NUM_LVL-1:0] levelHit;
  logic [PRIO_W-1:0] topLevel;
  logic [NUM_CH-1:0] winMask;
  logic [NUM_CH-1:0] pick;

  // One membership mask per priority level.
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign levelMask[l][c] = (chPrio[c*PRIO_W +: PRIO_W] == PRIO_W'(l));
    end
    assign levelHit[l] = |(eligible & levelMask[l]);
  end

  // Highest level that has an eligible requester.
  always_comb begin
    topLevel = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (levelHit[l]) topLevel = PRIO_W'(l);
    end
  end

  // Lowest index among the winners of the top level.
  always_comb begin
    winMask = eligible & levelMask[topLevel];
    pick    = winMask & (~winMask + NUM_CH'(1));
  end

  always_comb begin
    strobe.cpuTake = cpuReq;
    strobe.gnt     = cpuReq ? '0 : pick;
    strobe.anyGnt  = !cpuReq && (|pick);
  end
endmodule

// File: rtl/dma_arb_dpath.sv
module dma_arb_dpath
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH-1:0]        chStart,
  input  logic [NUM_CH*LEN_W-1:0]  chLen,
  input  logic [NUM_CH*ADDR_W-1:0] chBase,
  input  logic [ADDR_W-1:0]        m2mDst,
  input  logic [NUM_CH-1:0]        dmaReq,
  input  logic [NUM_CH-1:0]        dmaWr,
  input  logic [NUM_CH*DATA_W-1:0] dmaWdata,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuWdata,
  input  logic [DATA_W-1:0]        ramRdata,
  input  strobe_t                  strobe,
  output logic [NUM_CH-1:0]        eligible,
  output logic [NUM_CH-1:0]        chActive,
  output logic [NUM_CH-1:0]        dmaDone,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]        ramWdata,
  output logic                     ramWe,
  output logic                     ramEn
);
  logic [ADDR_W-1:0] chAddr   [NUM_CH];
  logic [LEN_W-1:0]  chRemain [NUM_CH];
  logic [NUM_CH-1:0] addrStep;
  logic [NUM_CH-1:0] byteStep;

  logic              m2mPhase;   // 0: read source, 1: write destination
  logic [ADDR_W-1:0] m2mDstAddr;
  logic [DATA_W-1:0] m2mBuf;

  assign eligible = dmaReq & chEnable & chActive;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    if (i == M2M_CH) begin : g_mover
      assign addrStep[i] = strobe.gnt[i] && !m2mPhase;
      assign byteStep[i] = strobe.gnt[i] && m2mPhase;
    end else begin : g_plain
      assign addrStep[i] = strobe.gnt[i];
      assign byteStep[i] = strobe.gnt[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chActive[i] <= 1'b0;
        chRemain[i] <= '0;
        chAddr[i]   <= '0;
        dmaDone[i]  <= 1'b0;
      end else begin
        dmaDone[i] <= 1'b0;
        if (chStart[i] && chEnable[i]) begin
          chActive[i] <= 1'b1;
          chRemain[i] <= chLen[i*LEN_W +: LEN_W];
          chAddr[i]   <= chBase[i*ADDR_W +: ADDR_W];
        end else begin
          if (addrStep[i]) chAddr[i] <= chAddr[i] + ADDR_W'(1);
          if (byteStep[i]) begin
            if (chRemain[i] == '0) begin
              chActive[i] <= 1'b0;
              dmaDone[i]  <= 1'b1;
            end else begin
              chRemain[i] <= chRemain[i] - LEN_W'(1);
            end
          end
        end
      end
    end
  end

  // Memory-to-memory phase, destination pointer and holding byte.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      m2mPhase   <= 1'b0;
      m2mDstAddr <= '0;
      m2mBuf     <= '0;
    end else if (chStart[M2M_CH] && chEnable[M2M_CH]) begin
      m2mPhase   <= 1'b0;
      m2mDstAddr <= m2mDst;
    end else if (strobe.gnt[M2M_CH]) begin
      if (!m2mPhase) begin
        m2mBuf   <= ramRdata;
        m2mPhase <= 1'b1;
      end else begin
        m2mPhase   <= 1'b0;
        m2mDstAddr <= m2mDstAddr + ADDR_W'(1);
      end
    end
  end

  // Index of the granted channel.
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strobe.gnt[i]) selIdx = IDX_W'(i);
    end
  end

  // RAM port steering: CPU first, then the single DMA winner.
  always_comb begin
    ramEn    = strobe.cpuTake || strobe.anyGnt;
    ramAddr  = cpuAddr;
    ramWdata = cpuWdata;
    ramWe    = 1'b0;
    if (strobe.cpuTake) begin
      ramWe = cpuWe;
    end else if (strobe.anyGnt) begin
      if (selIdx == IDX_W'(M2M_CH)) begin
        ramAddr  = m2mPhase ? m2mDstAddr : chAddr[M2M_CH];
        ramWdata = m2mBuf;
        ramWe    = m2mPhase;
      end else begin
        ramAddr  = chAddr[selIdx];
        ramWdata = dmaWdata[selIdx*DATA_W +: DATA_W];
        ramWe    = dmaWr[selIdx];
      end
    end
  end
endmodule

// File: rtl/dma_ram_arbiter.sv
module dma_ram_arbiter
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        chEnable,
  input  logic [NUM_CH-1:0]        chStart,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  logic [NUM_CH*LEN_W-1:0]  chLen,
  input  logic [NUM_CH*ADDR_W-1:0] chBase,
  input  logic [ADDR_W-1:0]        m2mDst,
  input  logic [NUM_CH-1:0]        dmaReq,
  input  logic [NUM_CH-1:0]        dmaWr,
  input  logic [NUM_CH*DATA_W-1:0] dmaWdata,
  output logic [NUM_CH-1:0]        dmaGnt,
  output logic [NUM_CH-1:0]        dmaDone,
  output logic [DATA_W-1:0]        dmaRdata,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [DATA_W-1:0]        cpuWdata,
  output logic [DATA_W-1:0]        cpuRdata,
  output logic [ADDR_W-1:0]        ramAddr,
  output logic [DATA_W-1:0]        ramWdata,
  output logic                     ramWe,
  output logic                     ramEn,
  input  logic [DATA_W-1:0]        ramRdata
);
  strobe_t           strobe;
  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] chActive;

  dma_arb_ctrl u_ctrl (
    .eligible (eligible),
    .chPrio   (chPrio),
    .cpuReq   (cpuReq),
    .strobe   (strobe)
  );

  dma_arb_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .chEnable (chEnable),
    .chStart  (chStart),
    .chLen    (chLen),
    .chBase   (chBase),
    .m2mDst   (m2mDst),
    .dmaReq   (dmaReq),
    .dmaWr    (dmaWr),
    .dmaWdata (dmaWdata),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .ramRdata (ramRdata),
    .strobe   (strobe),
    .eligible (eligible),
    .chActive (chActive),
    .dmaDone  (dmaDone),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .ramWe    (ramWe),
    .ramEn    (ramEn)
  );

  assign dmaGnt   = strobe.gnt;
  assign dmaRdata = ramRdata;
  assign cpuRdata = ramRdata;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cpuReq,
  input logic [ADDR_W-1:0]        cpuAddr,
  input logic [ADDR_W-1:0]        ramAddr,
  input logic                     ramEn,
  input logic [NUM_CH-1:0]        dmaReq,
  input logic [NUM_CH-1:0]        dmaGnt,
  input logic [NUM_CH-1:0]        dmaDone,
  input logic [NUM_CH-1:0]        chEnable,
  input logic [NUM_CH-1:0]        chActive,
  input logic [NUM_CH*PRIO_W-1:0] chPrio
);
  logic [NUM_CH-1:0] live;
  logic              rankBad;

  assign live = dmaReq & chEnable & chActive;

  // A grant is wrong if some live channel outranks the granted one (R1, R2).
  always_comb begin
    rankBad = 1'b0;
    for (int g = 0; g < NUM_CH; g++) begin
      for (int j = 0; j < NUM_CH; j++) begin
        if (dmaGnt[g] && live[j] && j != g) begin
          if (chPrio[j*PRIO_W +: PRIO_W] > chPrio[g*PRIO_W +: PRIO_W]) rankBad = 1'b1;
          if (chPrio[j*PRIO_W +: PRIO_W] == chPrio[g*PRIO_W +: PRIO_W] && j < g) rankBad = 1'b1;
        end
      end
    end
  end

  p_gnt_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dmaGnt));

  p_gnt_live_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt & ~live) == '0);

  p_gnt_rank_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rankBad);

  p_cpu_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq |-> (dmaGnt == '0 && ramAddr == cpuAddr && ramEn));

  p_done_after_gnt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (dmaDone & ~$past(dmaGnt)) == '0);

  p_masked_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGnt & ~chEnable) == '0);

  p_quiet_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dmaGnt == '0 && dmaDone == '0));
endmodule

bind dma_ram_arbiter dma_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuAddr  (cpuAddr),
  .ramAddr  (ramAddr),
  .ramEn    (ramEn),
  .dmaReq   (dmaReq),
  .dmaGnt   (dmaGnt),
  .dmaDone  (dmaDone),
  .chEnable (chEnable),
  .chActive (chActive),
  .chPrio   (chPrio)
);

// File: tb/test_dma_ram_arbiter.sv
`timescale 1ns/1ps
module test_dma_ram_arbiter;
  localparam int NCH = 12;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int LW  = 8;
  localparam int PW  = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NCH-1:0]    chEnable, chStart, dmaReq, dmaWr;
  logic [NCH*PW-1:0] chPrio;
  logic [NCH*LW-1:0] chLen;
  logic [NCH*AW-1:0] chBase;
  logic [AW-1:0]     m2mDst;
  logic [NCH*DW-1:0] dmaWdata;
  logic [NCH-1:0]    dmaGnt, dmaDone;
  logic [DW-1:0]     dmaRdata, cpuRdata, cpuWdata, ramWdata, ramRdata;
  logic              cpuReq, cpuWe, ramWe, ramEn;
  logic [AW-1:0]     cpuAddr, ramAddr;

  logic [DW-1:0] mem [1024];
  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_ram_arbiter i_dma_ram_arbiter (
    .clk(clk), .rstN(rstN), .chEnable(chEnable), .chStart(chStart),
    .chPrio(chPrio), .chLen(chLen), .chBase(chBase), .m2mDst(m2mDst),
    .dmaReq(dmaReq), .dmaWr(dmaWr), .dmaWdata(dmaWdata), .dmaGnt(dmaGnt),
    .dmaDone(dmaDone), .dmaRdata(dmaRdata), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe), .ramEn(ramEn),
    .ramRdata(ramRdata)
  );

  // Behavioural RAM: asynchronous read, write at the clock edge.
  assign ramRdata = mem[ramAddr[9:0]];
  always @(posedge clk) if (ramEn && ramWe) mem[ramAddr[9:0]] <= ramWdata;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic cfg(int ch, int prio, int len, int base);
    chPrio[ch*PW +: PW] = PW'(prio);
    chLen[ch*LW +: LW]  = LW'(len);
    chBase[ch*AW +: AW] = AW'(base);
    chEnable[ch] = 1'b1;
  endtask

  task automatic startCh(logic [NCH-1:0] mask);
    chStart = mask;
    step();
    chStart = '0;
  endtask

  task automatic cpuWrite(int addr, int data);
    cpuReq = 1; cpuWe = 1; cpuAddr = AW'(addr); cpuWdata = DW'(data);
    step();
    cpuReq = 0; cpuWe = 0;
  endtask

  task automatic cpuReadCheck(string tag, int addr, int exp);
    cpuReq = 1; cpuWe = 0; cpuAddr = AW'(addr);
    #1;
    check(tag, 32'(cpuRdata), 32'(exp));
    cpuReq = 0;
  endtask

  task automatic t_reset();
    dmaReq = '1;
    step();
    check("R9 no grant after reset", 32'(dmaGnt), 0);
    check("R9 no done after reset", 32'(dmaDone), 0);
    dmaReq = '0;
  endtask

  task automatic t_tie();
    cfg(1, 2, 0, 'h10); cfg(2, 2, 0, 'h20); cfg(5, 2, 0, 'h30);
    startCh(12'b0000_0010_0110);
    dmaReq = 12'b0000_0010_0110;
    #1;
    check("R1 lowest index wins tie", 32'(dmaGnt), 32'(1 << 1));
    check("R6 address of first byte", 32'(ramAddr), 'h10);
    step();
    check("R5 done after single byte", 32'(dmaDone), 32'(1 << 1));
    check("R10 next tied requester served", 32'(dmaGnt), 32'(1 << 2));
    step();
    check("R10 last tied requester served", 32'(dmaGnt), 32'(1 << 5));
    step();
    check("R5 finished channels not regranted", 32'(dmaGnt), 0);
    dmaReq = '0;
  endtask

  task automatic t_prio();
    cfg(0, 1, 0, 'h40); cfg(4, 3, 0, 'h44); cfg(7, 3, 0, 'h47);
    startCh(12'b0000_1001_0001);
    dmaReq = 12'b0000_1001_0001;
    #1;
    check("R2 level 3 beats level 1", 32'(dmaGnt), 32'(1 << 4));
    step();
    check("R2 remaining level 3 wins", 32'(dmaGnt), 32'(1 << 7));
    step();
    check("R10 low priority finally served", 32'(dmaGnt), 32'(1 << 0));
    step();
    dmaReq = '0;
  endtask

  task automatic t_cpu();
    cfg(0, 3, 0, 'h60);
    dmaWr[0] = 1'b0;
    startCh(12'b1);
    dmaReq = 12'b1;
    cpuReq = 1; cpuWe = 1; cpuAddr = 'h50; cpuWdata = 'h5A;
    #1;
    check("R3 cpu blocks dma grant", 32'(dmaGnt), 0);
    check("R3 cpu address on port", 32'(ramAddr), 'h50);
    check("R3 cpu write enable on port", 32'(ramWe), 1);
    step();
    cpuReq = 0; cpuWe = 0;
    #1;
    check("R10 deferred channel granted", 32'(dmaGnt), 1);
    step();
    dmaReq = '0;
    cpuReadCheck("R3 cpu write landed", 'h50, 'h5A);
  endtask

  task automatic t_len();
    cfg(11, 0, 3, 'h100);
    dmaWr[11] = 1'b1;
    startCh(12'b1000_0000_0000);
    dmaReq = 12'b1000_0000_0000;
    for (int k = 0; k < 4; k++) begin
      dmaWdata[11*DW +: DW] = DW'('hA0 + k);
      #1;
      check("R6 grant and address per byte",
            {dmaGnt, 4'h0, ramAddr}, {12'h800, 4'h0, 16'(16'h100 + k)});
      check("R6 direction from request", 32'(ramWe), 1);
      step();
    end
    check("R5 done after L+1 bytes", 32'(dmaDone), 32'(1 << 11));
    check("R5 no grant past length", 32'(dmaGnt), 0);
    step();
    check("R5 done lasts one cycle", 32'(dmaDone), 0);
    dmaReq = '0;
    cpuReadCheck("R6 first byte stored", 'h100, 'hA0);
    cpuReadCheck("R6 last byte stored", 'h103, 'hA3);
  endtask

  task automatic t_disable();
    cfg(3, 3, 0, 'h180);
    startCh(12'b1000);
    chEnable[3] = 1'b0;
    dmaReq = 12'b1000;
    #1;
    check("R8 disabled channel masked", 32'(dmaGnt), 0);
    step();
    check("R8 still masked next cycle", 32'(dmaGnt), 0);
    chEnable[3] = 1'b1;
    #1;
    check("R8 re-enabled channel resumes", 32'(dmaGnt), 32'(1 << 3));
    step();
    dmaReq = '0;
  endtask

  task automatic t_m2m();
    cpuWrite('h200, 'h11); cpuWrite('h201, 'h22); cpuWrite('h202, 'h33);
    cfg(10, 1, 2, 'h200);
    m2mDst = 'h300;
    startCh(12'b0100_0000_0000);
    dmaReq = 12'b0100_0000_0000;
    for (int c = 0; c < 6; c++) begin
      #1;
      check("R7 mover grant, address and direction",
            {dmaGnt, 3'b0, ramWe, ramAddr},
            {12'h400, 3'b0, 1'(c % 2),
             16'((c % 2) ? 16'h300 + c / 2 : 16'h200 + c / 2)});
      step();
    end
    check("R7 done after final write", 32'(dmaDone), 32'(1 << 10));
    dmaReq = '0;
    cpuReadCheck("R7 copied byte 0", 'h300, 'h11);
    cpuReadCheck("R7 copied byte 2", 'h302, 'h33);
  endtask

  task automatic t_midreset();
    cfg(5, 2, 5, 'h1C0);
    startCh(12'b10_0000);
    dmaReq = 12'b10_0000;
    #1;
    check("R5 long transfer granted", 32'(dmaGnt), 32'(1 << 5));
    rstN = 0;
    step();
    rstN = 1;
    #1;
    check("R9 reset aborts transfer", 32'(dmaGnt), 0);
    step();
    dmaReq = '0;
  endtask

  initial begin
    rstN = 0; chEnable = '0; chStart = '0; chPrio = '0; chLen = '0;
    chBase = '0; m2mDst = '0; dmaReq = '0; dmaWr = '0; dmaWdata = '0;
    cpuReq = 0; cpuWe = 0; cpuAddr = '0; cpuWdata = '0;
    for (int a = 0; a < 1024; a++) mem[a] = '0;
    @(negedge clk); #1;
    dmaReq = '1;
    step(); step();
    rstN = 1;
    t_reset();
    t_tie();
    t_prio();
    t_cpu();
    t_len();
    t_disable();
    t_m2m();
    t_midreset();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule